// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Driver

This block controls the output driver of one legacy controller port pin that sits on a tristate pad with an external pull-up resistor. It turns a port data bit and a mode select into an output-enable and an output value for the pad. A port bit of 0 always pulls the pin low. In push-pull mode, a fresh 0-to-1 change of the port bit drives the pin high for a short, fixed burst of clock cycles so that the line rises quickly. After the burst the driver lets go, and the pull-up keeps the line high. In open-drain mode the driver never pushes the pin high. A port bit of 1 only releases the line, so other devices can share it.

The pad level comes back through a short synchronizer as a readback bit. This lets the controller see a low that another device puts on a shared line. All inputs are sampled on the rising clock edge, and both pad controls come straight from flops.

Top module: `qbd_pin_driver`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls with `port_bit` at 1, `pad_oe` is 0 and `pad_out` is 1. The reset state of the previous port bit is 1, so no pulse starts after reset.
- R2: A `port_bit` of 0 makes `pad_oe`=1 and `pad_out`=0 from the next rising edge on, in either mode (`od_mode`=0 push-pull, `od_mode`=1 open-drain).
- R3: In push-pull mode, the edge that first samples `port_bit`=1 after a 0 sets `pad_oe`=1 and `pad_out`=1.
- R4: With `port_bit` held at 1 in push-pull mode, the high drive lasts exactly `PULSE_CYCLES` (default 6) clock cycles. Then `pad_oe` returns to 0 and `pad_out` stays 1.
- R5: In open-drain mode, `pad_oe` and `pad_out` are never both 1. Raising `od_mode` during a high pulse releases the pin at the next edge.
- R6: If `port_bit` returns to 0 during a high pulse, the pulse is cancelled and the pin is driven low at the next edge. A later rise starts a full new pulse.
- R7: A `port_bit` that stays at 1 never restarts the pulse. This includes a switch from open-drain to push-pull while the bit stays 1.
- R8: The pin is never inverted. Whenever `pad_oe` is 1, `pad_out` equals the `port_bit` sampled at the previous edge.
- R9: `pad_level` shows `pad_in` delayed by `SYNC_STAGES` (default 2) rising edges, and it resets to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| port_bit | input | 1 | Port data bit for this pin |
| od_mode | input | 1 | 1 = open-drain, 0 = push-pull with a high pulse |
| pad_in | input | 1 | Level seen at the pad |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Value driven when `pad_oe` is 1 |
| pad_level | output | 1 | Synchronized pad level readback |

## Verification
The drive results for `pad_oe` and `pad_out` are registered. Each one is due at the first rising edge after the stimulus. The high burst stays on for edges 1 through `PULSE_CYCLES`, and the release is due at edge `PULSE_CYCLES`+1. The readback bit follows `pad_in` after `SYNC_STAGES` edges. The bench changes inputs on falling edges and reads outputs on later falling edges. It counts edges one at a time, so every check falls on the cycle in which the result is due, or just before it for the readback delay.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
  // Drive request for a tristate pad: enable plus value.
  typedef struct packed {
    logic oe;
    logic val;
  } pin_drive_t;

  localparam pin_drive_t DRIVE_LOW  = '{oe: 1'b1, val: 1'b0};
  localparam pin_drive_t DRIVE_HIGH = '{oe: 1'b1, val: 1'b1};
  localparam pin_drive_t RELEASED   = '{oe: 1'b0, val: 1'b1};
endpackage

// File: rtl/qbd_edge_detect.sv
module qbd_edge_detect #(
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RESET_LEVEL;
    else     prev_q <= d;
  end

  assign rise = d & ~prev_q;
endmodule

// File: rtl/qbd_pulse_timer.sv
module qbd_pulse_timer #(
  parameter int PULSE_CYCLES = 6,
  localparam int CNT_W = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cancel,
  output logic hold
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_CYCLES - 1);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)                   remain_q <= '0;
    else if (cancel)           remain_q <= '0;
    else if (start)            remain_q <= LOAD_VAL;
    else if (remain_q != '0)   remain_q <= remain_q - CNT_W'(1);
  end

  // Cycles of high drive still owed after the one just driven.
  assign hold = (remain_q != '0);
endmodule

// File: rtl/qbd_pad_sync.sv
module qbd_pad_sync #(
  parameter int   STAGES      = 2,
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= RESET_LEVEL;
          else     chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= RESET_LEVEL;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/qbd_pin_driver.sv
module qbd_pin_driver #(
  parameter int PULSE_CYCLES = 6,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic port_bit,
  input  logic od_mode,
  input  logic pad_in,
  output logic pad_oe,
  output logic pad_out,
  output logic pad_level
);
  import qbd_pkg::*;

  logic       rise;
  logic       hold;
  logic       start_pulse;
  logic       cancel_pulse;
  pin_drive_t drive_d;
  pin_drive_t drive_q;

  qbd_edge_detect #(.RESET_LEVEL(1'b1)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .d    (port_bit),
    .rise (rise)
  );

  assign start_pulse  = rise & ~od_mode;
  assign cancel_pulse = ~port_bit | od_mode;

  qbd_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (start_pulse),
    .cancel (cancel_pulse),
    .hold   (hold)
  );

  always_comb begin
    if (!port_bit)        drive_d = DRIVE_LOW;
    else if (od_mode)     drive_d = RELEASED;
    else if (start_pulse) drive_d = DRIVE_HIGH;
    else if (hold)        drive_d = DRIVE_HIGH;
    else                  drive_d = RELEASED;
  end

  always_ff @(posedge clk) begin
    if (rst) drive_q <= RELEASED;
    else     drive_q <= drive_d;
  end

  assign pad_oe  = drive_q.oe;
  assign pad_out = drive_q.val;

  qbd_pad_sync #(.STAGES(SYNC_STAGES), .RESET_LEVEL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pad_level)
  );
endmodule

// File: rtl/qbd_pin_driver_chk.sv
module qbd_pin_driver_chk #(
  parameter int PULSE_CYCLES = 6,
  localparam int RUN_W = $clog2(PULSE_CYCLES + 2)
) (
  input logic clk,
  input logic rst,
  input logic port_bit,
  input logic od_mode,
  input logic pad_oe,
  input logic pad_out
);
  logic [RUN_W-1:0] high_run;

  always_ff @(posedge clk) begin
    if (rst)                    high_run <= '0;
    else if (pad_oe && pad_out) begin
      if (high_run != RUN_W'(PULSE_CYCLES + 1)) high_run <= high_run + RUN_W'(1);
    end
    else                        high_run <= '0;
  end

  AST_RESET_RELEASED: assert property (@(posedge clk) $past(rst) |-> (!pad_oe && pad_out)); // R1
  AST_LOW_DRIVE: assert property (@(posedge clk) disable iff (rst) !port_bit |=> (pad_oe && !pad_out)); // R2
  AST_RISE_HIGH: assert property (@(posedge clk) disable iff (rst) (port_bit && !$past(port_bit) && !$past(rst) && !od_mode) |=> (pad_oe && pad_out)); // R3
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst) high_run <= RUN_W'(PULSE_CYCLES)); // R4
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (rst) od_mode |=> !(pad_oe && pad_out)); // R5
  AST_NO_INVERT: assert property (@(posedge clk) disable iff (rst) (pad_oe && !$past(rst)) |-> (pad_out == $past(port_bit))); // R8
endmodule

bind qbd_pin_driver qbd_pin_driver_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .port_bit (port_bit),
  .od_mode  (od_mode),
  .pad_oe   (pad_oe),
  .pad_out  (pad_out)
);

// File: tb/tb_qbd_pin_driver.sv
module tb_qbd_pin_driver;
  localparam int PULSE = 6;
  localparam int SYNC  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_bit = 1'b0;
  logic od_mode = 1'b0;
  logic ext_low = 1'b0;
  logic pad_in;
  logic pad_oe, pad_out, pad_level;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  // Pad with pull-up, optionally pulled low by another device.
  assign pad_in = ext_low ? 1'b0 : (pad_oe ? pad_out : 1'b1);

  qbd_pin_driver #(.PULSE_CYCLES(PULSE), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .port_bit(port_bit), .od_mode(od_mode),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_level(pad_level)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_drive(string req, logic exp_oe, logic exp_out);
    checks++;
    if (pad_oe !== exp_oe || pad_out !== exp_out) begin
      errors++;
      $display("FAIL %s: oe/out actual %b%b expected %b%b", req, pad_oe, pad_out, exp_oe, exp_out);
    end
  endtask

  task automatic chk_level(string req, logic exp);
    checks++;
    if (pad_level !== exp) begin
      errors++;
      $display("FAIL %s: pad_level actual %b expected %b", req, pad_level, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; port_bit = 1'b0; od_mode = 1'b0;
    tick(); tick();
    chk_drive("R1 in reset", 1'b0, 1'b1);
    chk_level("R9 reset value", 1'b1);
    port_bit = 1'b1; rst = 1'b0;
    tick();
    chk_drive("R1 after reset", 1'b0, 1'b1);
    tick(); tick();
    chk_drive("R1 no pulse after reset", 1'b0, 1'b1);
  endtask

  task automatic t_low_and_od();
    od_mode = 1'b0; port_bit = 1'b0;
    tick();
    chk_drive("R2 low push-pull", 1'b1, 1'b0);
    od_mode = 1'b1;
    tick();
    chk_drive("R2 low open-drain", 1'b1, 1'b0);
    checks++;
    if (pad_oe && pad_out !== 1'b0) begin
      errors++;
      $display("FAIL R8: pad_out actual %b expected 0", pad_out);
    end
    port_bit = 1'b1;
    for (int i = 1; i <= PULSE + 2; i++) begin
      tick();
      chk_drive("R5 open-drain release", 1'b0, 1'b1);
    end
    od_mode = 1'b0;
    for (int i = 1; i <= 3; i++) begin
      tick();
      chk_drive("R7 mode switch no pulse", 1'b0, 1'b1);
    end
  endtask

  task automatic t_pulse();
    od_mode = 1'b0; port_bit = 1'b0;
    tick();
    port_bit = 1'b1;
    tick();
    chk_drive("R3 rise drives high", 1'b1, 1'b1);
    for (int i = 2; i <= PULSE; i++) begin
      tick();
      chk_drive("R4 R8 pulse high", 1'b1, 1'b1);
    end
    tick();
    chk_drive("R4 pulse ends", 1'b0, 1'b1);
    for (int i = 1; i <= 4; i++) begin
      tick();
      chk_drive("R7 held one no retrigger", 1'b0, 1'b1);
    end
  endtask

  task automatic t_cancel();
    od_mode = 1'b0; port_bit = 1'b0;
    tick();
    port_bit = 1'b1;
    tick(); tick(); tick();
    chk_drive("R6 pulse running", 1'b1, 1'b1);
    port_bit = 1'b0;
    tick();
    chk_drive("R6 cancel drives low", 1'b1, 1'b0);
    port_bit = 1'b1;
    for (int i = 1; i <= PULSE; i++) begin
      tick();
      chk_drive("R6 full new pulse", 1'b1, 1'b1);
    end
    tick();
    chk_drive("R6 new pulse ends", 1'b0, 1'b1);
  endtask

  task automatic t_od_mid_pulse();
    od_mode = 1'b0; port_bit = 1'b0;
    tick();
    port_bit = 1'b1;
    tick(); tick();
    chk_drive("R5 pulse before mode change", 1'b1, 1'b1);
    od_mode = 1'b1;
    tick();
    chk_drive("R5 od releases mid-pulse", 1'b0, 1'b1);
    od_mode = 1'b0;
    tick(); tick();
    chk_drive("R7 pulse not resumed", 1'b0, 1'b1);
  endtask

  task automatic t_readback();
    od_mode = 1'b1; port_bit = 1'b1;
    tick(); tick(); tick();
    chk_level("R9 released line high", 1'b1);
    ext_low = 1'b1;
    for (int i = 1; i < SYNC; i++) begin
      tick();
      chk_level("R9 before delay elapses", 1'b1);
    end
    tick();
    chk_level("R9 shared low seen", 1'b0);
    ext_low = 1'b0;
    for (int i = 1; i < SYNC; i++) begin
      tick();
      chk_level("R9 low still in sync", 1'b0);
    end
    tick();
    chk_level("R9 high seen again", 1'b1);
  endtask

  initial begin
    t_reset();
    t_low_and_od();
    t_pulse();
    t_cancel();
    t_od_mid_pulse();
    t_readback();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule